// File: doc/BRIEF.md
# Dual-Stream Multiplexed DAC Output Port

This block merges two 16-bit sample streams onto one 16-bit converter bus: a transmit stream and an echo-cancel stream. It also generates the qualifying clock that goes with that bus. Transmit samples occupy the bus while the qualifying clock is low, so the converter captures them on its rising edge. Echo samples occupy the bus while the clock is high, so they are captured on its falling edge. The block runs from a master clock at twice the qualifying-clock rate of the fastest mode, and derives the qualifying clock by counting master cycles.

Three rate modes stretch the qualifying-clock period. The transmit and echo streams always share one mode. At the normal rate the period is 2 master cycles, at the half rate it is 4, and at the slowest rate it is 16. With a 35.328 MHz master clock this gives per-stream rates of 17.664, 8.832 and 2.208 Msps.

Each stream is pulled from upstream with a valid/ready handshake. The ready strobe lasts one cycle and comes once per qualifying-clock period. Input samples are two's complement. The bus can carry them unchanged, or in offset binary, which is the default. Mode and format are sampled only at period boundaries, so a period is never cut short.

Top module: `dual_stream_dac_port`

## Requirements
- R1: While rst_n is low, dac_qclk is 0, dac_bus is 16'h8000, and both tx_ready and ec_ready are 0.
- R2: The qualifying clock's high and low phases each last 1 master cycle for cfg_rate code 0, 2 cycles for code 1, and 8 cycles for codes 2 and 3.
- R3: dac_bus changes only on the master edge where dac_qclk toggles. The transmit slot is shown while dac_qclk is low and the echo slot while it is high.
- R4: tx_ready is a one-cycle strobe in the last master cycle of each qualifying-clock period. A sample taken with tx_valid at that strobe is shown in the next low phase.
- R5: ec_ready is a one-cycle strobe in the last master cycle of each low phase. A sample taken with ec_valid at that strobe is shown in the following high phase.
- R6: tx_ready and ec_ready are never high in the same cycle.
- R7: If a stream's valid is low at its strobe, that stream's slot repeats its last accepted sample. Before any sample is accepted, the repeated value is zero (mid-scale).
- R8: With cfg_twos at 0 the bus carries the sample with bit 15 inverted (offset binary). With cfg_twos at 1 the sample passes unchanged. cfg_twos is sampled in the tx_ready cycle and governs both slots of the period that follows.
- R9: cfg_rate is sampled only in the tx_ready cycle. A change at any other time does not alter the current period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rate | input | 2 | Rate mode code (0 normal, 1 half, 2/3 slowest) |
| cfg_twos | input | 1 | 1 = two's complement output, 0 = offset binary |
| tx_data | input | 16 | Transmit sample, two's complement |
| tx_valid | input | 1 | Transmit sample available |
| tx_ready | output | 1 | Transmit take strobe |
| ec_data | input | 16 | Echo-cancel sample, two's complement |
| ec_valid | input | 1 | Echo sample available |
| ec_ready | output | 1 | Echo take strobe |
| dac_bus | output | 16 | Multiplexed converter bus |
| dac_qclk | output | 1 | Qualifying clock for dac_bus |

## Verification
The properties assume several things about the inputs. Reset is asynchronous, is held for several cycles, and is released away from a rising master edge. tx_data, ec_data, both valids and both configuration inputs are stable around every rising master edge. Any 2-bit rate code is legal at any time. The stimulus meets these assumptions by changing every input only on falling master edges. It deliberately moves cfg_rate and cfg_twos in the middle of periods, and it drops the valids at random. This checks that mid-period changes are ignored and that an underrun repeats the held sample.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
    typedef enum logic [1:0] {
        RATE_FULL = 2'd0,
        RATE_HALF = 2'd1,
        RATE_SLOW = 2'd2,
        RATE_SLOW_ALT = 2'd3
    } rate_t;
endpackage

// File: rtl/dsd_phase_gen.sv
module dsd_phase_gen
    import dsd_pkg::*;
#(
    parameter int HALF_FULL = 1,
    parameter int HALF_HALF = 2,
    parameter int HALF_SLOW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_in,
    output logic       mid_stb,
    output logic       end_stb
);
    localparam int CNT_W = $clog2(2 * HALF_SLOW);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        rate_t            rate;
    } ph_t;

    ph_t              ph_d, ph_q;
    logic [CNT_W-1:0] mid_val, end_val;

    always_comb begin
        case (ph_q.rate)
            RATE_FULL: begin
                mid_val = CNT_W'(HALF_FULL - 1);
                end_val = CNT_W'(2 * HALF_FULL - 1);
            end
            RATE_HALF: begin
                mid_val = CNT_W'(HALF_HALF - 1);
                end_val = CNT_W'(2 * HALF_HALF - 1);
            end
            default: begin
                mid_val = CNT_W'(HALF_SLOW - 1);
                end_val = CNT_W'(2 * HALF_SLOW - 1);
            end
        endcase
        mid_stb = (ph_q.cnt == mid_val);
        end_stb = (ph_q.cnt == end_val);
        ph_d = ph_q;
        if (end_stb) begin
            ph_d.cnt  = '0;
            ph_d.rate = rate_t'(rate_in);   // mode only switches on a period boundary
        end else begin
            ph_d.cnt = ph_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '{cnt: '0, rate: RATE_FULL};
        end else begin
            ph_q <= ph_d;
        end
    end
endmodule

// File: rtl/dsd_sample_hold.sv
module dsd_sample_hold #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic [W-1:0] hold_nxt
);
    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (take && in_valid) begin
            hold_d = in_data;
        end
        hold_nxt = hold_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;   // two's complement zero = mid-scale
        end else begin
            hold_q <= hold_d;
        end
    end
endmodule

// File: rtl/dual_stream_dac_port.sv
module dual_stream_dac_port #(
    parameter int DATA_W    = 16,
    parameter int HALF_FULL = 1,
    parameter int HALF_HALF = 2,
    parameter int HALF_SLOW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_rate,
    input  logic              cfg_twos,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic [DATA_W-1:0] ec_data,
    input  logic              ec_valid,
    output logic              ec_ready,
    output logic [DATA_W-1:0] dac_bus,
    output logic              dac_qclk
);
    localparam logic [DATA_W-1:0] BUS_RST = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] bus;
        logic              qclk;
        logic              twos;
    } out_t;

    out_t              st_d, st_q;
    logic              mid_stb, end_stb;
    logic [DATA_W-1:0] tx_nxt, ec_nxt;

    function automatic logic [DATA_W-1:0] to_bus(input logic [DATA_W-1:0] s, input logic twos);
        return twos ? s : {~s[DATA_W-1], s[DATA_W-2:0]};
    endfunction

    dsd_phase_gen #(
        .HALF_FULL(HALF_FULL),
        .HALF_HALF(HALF_HALF),
        .HALF_SLOW(HALF_SLOW)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_in (cfg_rate),
        .mid_stb (mid_stb),
        .end_stb (end_stb)
    );

    assign tx_ready = end_stb & rst_n;
    assign ec_ready = mid_stb & rst_n;

    dsd_sample_hold #(.W(DATA_W)) u_tx_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (tx_ready),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .hold_nxt (tx_nxt)
    );

    dsd_sample_hold #(.W(DATA_W)) u_ec_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (ec_ready),
        .in_valid (ec_valid),
        .in_data  (ec_data),
        .hold_nxt (ec_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (tx_ready) begin
            // new period: clock falls, transmit slot loads, format latched
            st_d.qclk = 1'b0;
            st_d.twos = cfg_twos;
            st_d.bus  = to_bus(tx_nxt, cfg_twos);
        end else if (ec_ready) begin
            // mid period: clock rises, echo slot loads
            st_d.qclk = 1'b1;
            st_d.bus  = to_bus(ec_nxt, st_q.twos);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bus: BUS_RST, qclk: 1'b0, twos: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dac_bus  = st_q.bus;
    assign dac_qclk = st_q.qclk;
endmodule

// File: rtl/dsd_port_checks.sv
module dsd_port_checks #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_twos,
    input logic [W-1:0] tx_data,
    input logic         tx_valid,
    input logic         tx_ready,
    input logic         ec_ready,
    input logic [W-1:0] dac_bus,
    input logic         dac_qclk
);
    p_ready_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready && ec_ready));

    p_tx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    p_ec_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ec_ready |=> !ec_ready);

    p_low_after_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !dac_qclk);

    p_high_after_ec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ec_ready |=> dac_qclk);

    p_edge_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_qclk != $past(dac_qclk)) |-> $past(tx_ready || ec_ready));

    p_bus_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_ready || ec_ready) |=> $stable(dac_bus));

    p_tx_format_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && tx_valid) |=>
            dac_bus == {$past(tx_data[W-1]) ^ !$past(cfg_twos), $past(tx_data[W-2:0])});
endmodule

bind dual_stream_dac_port dsd_port_checks #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_twos (cfg_twos),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .ec_ready (ec_ready),
    .dac_bus  (dac_bus),
    .dac_qclk (dac_qclk)
);

// File: tb/sim_dual_stream_dac_port.sv
module sim_dual_stream_dac_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_rate = 2'd0;
    logic        cfg_twos = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] ec_data = '0;
    logic        ec_valid = 1'b0;
    logic        ec_ready;
    logic [15:0] dac_bus;
    logic        dac_qclk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_stream_dac_port u0 (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_twos(cfg_twos),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .ec_data(ec_data), .ec_valid(ec_valid), .ec_ready(ec_ready),
        .dac_bus(dac_bus), .dac_qclk(dac_qclk)
    );

    function automatic logic [15:0] expect_bus(input logic [15:0] s, input logic twos);
        return twos ? s : (s ^ 16'h8000);
    endfunction

    function automatic int half_of(input logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 8;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // scoreboard state
    logic [15:0] tx_q[$];
    logic [15:0] ec_q[$];
    logic [15:0] last_tx, last_ec, prev_bus;
    logic        bfmt, prev_qclk;
    logic [1:0]  pend_mode, per_mode;
    int          run;

    task automatic model_reset;
        tx_q.delete();
        ec_q.delete();
        tx_q.push_back(16'h8000);   // first transmit slot shows reset mid-scale
        last_tx = '0; last_ec = '0; prev_bus = 16'h8000;
        bfmt = 1'b0; prev_qclk = 1'b0;
        pend_mode = 2'd0; per_mode = 2'd0; run = 0;
    endtask

    // monitor: samples one step after each falling edge
    initial begin
        model_reset();
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                model_reset();
            end else begin
                if (tx_ready && ec_ready) check("R6 both strobes", 1, 0);
                if (dac_qclk != prev_qclk) begin
                    check("R2/R9 phase length", run, half_of(per_mode));
                    if (dac_qclk) begin
                        if (tx_q.size() == 0) check("R4 tx queue empty", 1, 0);
                        else check("R3/R4/R7/R8 tx slot", prev_bus, tx_q.pop_front());
                    end else begin
                        if (ec_q.size() == 0) check("R5 ec queue empty", 1, 0);
                        else check("R3/R5/R7/R8 ec slot", prev_bus, ec_q.pop_front());
                        per_mode = pend_mode;
                    end
                    run = 1;
                end else begin
                    run++;
                end
                if (tx_ready) begin
                    if (tx_valid) last_tx = tx_data;
                    bfmt = cfg_twos;
                    pend_mode = cfg_rate;
                    tx_q.push_back(expect_bus(last_tx, bfmt));
                end
                if (ec_ready) begin
                    if (ec_valid) last_ec = ec_data;
                    ec_q.push_back(expect_bus(last_ec, bfmt));
                end
                prev_qclk = dac_qclk;
                prev_bus = dac_bus;
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] step(input logic [15:0] v);
        logic [15:0] x = v;
        x ^= x << 7;
        x ^= x >> 9;
        x ^= x << 8;
        return x;
    endfunction

    // driver: all inputs change on falling edges
    task automatic drive_segment(input int cycles, input logic [1:0] rate, input logic twos,
                                 input int density, input bit jitter, input bit corners);
        logic [15:0] corner_v [4] = '{16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF};
        cfg_rate = rate;
        cfg_twos = twos;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            lfsr = step(lfsr);
            tx_valid = (int'(lfsr[6:0]) % 100) < density;
            ec_valid = (int'(lfsr[13:7]) % 100) < density;
            tx_data = corners ? corner_v[i % 4] : step(lfsr);
            ec_data = corners ? corner_v[(i + 1) % 4] : ~lfsr;
            if (jitter && lfsr[15:13] == 3'd0) begin
                cfg_rate = lfsr[1:0];   // R9: arbitrary mid-period changes
                cfg_twos = lfsr[2];
            end
        end
    endtask

    task automatic reset_checks;
        repeat (3) @(negedge clk);
        #1;
        check("R1 qclk in reset", dac_qclk, 0);
        check("R1 bus in reset", dac_bus, 16'h8000);
        check("R1 tx_ready in reset", tx_ready, 0);
        check("R1 ec_ready in reset", ec_ready, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        reset_checks();
        @(negedge clk);
        rst_n = 1'b1;
        drive_segment(200, 2'd0, 1'b0, 100, 0, 0);   // R2 normal, offset binary
        drive_segment(300, 2'd1, 1'b1, 100, 0, 0);   // R2 half rate, R8 two's complement
        drive_segment(600, 2'd2, 1'b0, 70, 0, 0);    // R2 slow, R7 gaps
        drive_segment(600, 2'd3, 1'b1, 70, 0, 0);    // R2 code 3
        drive_segment(200, 2'd0, 1'b0, 100, 0, 1);   // R8 corner values
        drive_segment(200, 2'd1, 1'b1, 100, 0, 1);
        drive_segment(300, 2'd0, 1'b0, 0, 0, 0);     // R7 no valid at all
        drive_segment(3000, 2'd0, 1'b0, 60, 1, 0);   // R9 jitter of configuration
        @(negedge clk);
        rst_n = 1'b0;                                 // R1 second reset
        tx_valid = 1'b0;
        ec_valid = 1'b0;
        reset_checks();
        @(negedge clk);
        rst_n = 1'b1;
        drive_segment(2000, 2'd2, 1'b1, 50, 1, 0);
        drive_segment(40, 2'd0, 1'b0, 100, 0, 0);
        if (n_cmp < 12) check("R2 check count", n_cmp, 12);
        finish_run();
    end
endmodule